// File: doc/BRIEF.md
# Four-Operation Integer Calculator Unit

This block is a parameterised integer arithmetic unit. It takes two operands of the same width and a two-bit operation selector. It returns a result of that same width, together with four status flags: overflow, divide-by-zero, zero and negative. The four operations are addition, subtraction, multiplication and truncating division. A build-time parameter fixes whether both operands are read as unsigned numbers or as two's complement signed numbers. The two readings are never mixed.

Every operation has a defined outcome when the true result cannot be represented. Overflow is flagged and the low bits of the exact result are delivered. A zero divisor yields a zero result and raises the divide-by-zero flag. The most negative signed value divided by minus one delivers the most negative value and raises overflow.

A second parameter chooses between two forms of the unit. In the default form, an output register stage samples the inputs on a clock edge and emits a one-cycle valid pulse. In the other form the unit is purely combinational.

Top module: `arith4_unit`

## Requirements
- R1: The selector codes are 00 add, 01 subtract, 10 multiply and 11 divide. The result is the low W bits of the exact mathematical result, except in the cases that R6 covers.
- R2: In unsigned mode, add and subtract raise overflow exactly when the true result lies outside 0 to 2^W-1, which means a carry out or a borrow.
- R3: In signed mode, add and subtract raise overflow exactly when the true result lies outside -2^(W-1) to 2^(W-1)-1.
- R4: Multiply raises overflow exactly when the full 2W-bit product does not fit in W bits under the selected mode.
- R5: Divide truncates the quotient toward zero and drops the remainder. Divide does not raise overflow except in the case that R7 covers.
- R6: Divide with a zero divisor delivers result 0, raises divide-by-zero and leaves overflow low. Divide-by-zero is never raised by any other operation or divisor.
- R7: In signed mode, the most negative value divided by -1 delivers the most negative value and raises overflow.
- R8: The zero flag is 1 exactly when the delivered result is 0. The negative flag equals the result MSB in signed mode and is always 0 in unsigned mode.
- R9: With the register stage, the result, the flags and a one-cycle valid pulse appear at the clock edge that samples in_valid high. While in_valid is low, valid stays low and the result and flags hold their values.
- R10: A synchronous reset clears the result, all flags and valid to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and selector are valid this cycle |
| op_a | input | W | First operand |
| op_b | input | W | Second operand (subtrahend, multiplier or divisor) |
| op_sel | input | 2 | Operation selector |
| res | output | W | Delivered result |
| flag_ovf | output | 1 | Range overflow |
| flag_dz | output | 1 | Divide by zero |
| flag_zero | output | 1 | Delivered result is zero |
| flag_neg | output | 1 | Delivered result is negative (signed mode only) |
| res_valid | output | 1 | One-cycle strobe marking new result and flags |

## Verification
With the register stage, each result is due exactly one clock edge after the edge that sees in_valid high. Inputs are driven on the falling edge, so the following falling edge is the first point at which the outputs are sampled. On every such falling edge where valid is high, the monitor pops one expected item, and a valid with nothing queued counts as an error. Idle cycles and resets are checked on the falling edge after the edge that acted on them.

// File: rtl/calc_pkg.sv
package calc_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_MUL = 2'b10,
      OP_DIV = 2'b11
   } calc_op_e;

   typedef struct packed {
      logic ovf;
      logic dz;
      logic zero;
      logic neg;
   } calc_flags_t;
endpackage

// File: rtl/calc_addsub.sv
module calc_addsub #(
   parameter int W   = 8,
   parameter bit SGN = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] y,
   output logic         ovf
);
   logic [W:0] ax, bx, sx;

   generate
      if (SGN) begin : g_sext
         assign ax = {a[W-1], a};
         assign bx = {b[W-1], b};
      end else begin : g_zext
         assign ax = {1'b0, a};
         assign bx = {1'b0, b};
      end
   endgenerate

   always_comb sx = sub ? (ax - bx) : (ax + bx);
   assign y = sx[W-1:0];

   // Exact W+1 bit result: signed overflow when the two top bits disagree,
   // unsigned overflow on carry or borrow.
   generate
      if (SGN) begin : g_sovf
         assign ovf = sx[W] ^ sx[W-1];
      end else begin : g_uovf
         assign ovf = sx[W];
      end
   endgenerate
endmodule

// File: rtl/calc_mul.sv
module calc_mul #(
   parameter int W   = 8,
   parameter bit SGN = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y,
   output logic         ovf
);
   localparam int PW = 2 * W;
   logic [PW-1:0] ae, be, prod;

   generate
      if (SGN) begin : g_sext
         assign ae = {{W{a[W-1]}}, a};
         assign be = {{W{b[W-1]}}, b};
      end else begin : g_zext
         assign ae = {{W{1'b0}}, a};
         assign be = {{W{1'b0}}, b};
      end
   endgenerate

   // Modulo 2^PW, the product of the extended operands is the exact product.
   assign prod = ae * be;
   assign y    = prod[W-1:0];

   generate
      if (SGN) begin : g_sovf
         assign ovf = prod[PW-1:W] != {W{prod[W-1]}};
      end else begin : g_uovf
         assign ovf = |prod[PW-1:W];
      end
   endgenerate
endmodule

// File: rtl/calc_div.sv
module calc_div #(
   parameter int W   = 8,
   parameter bit SGN = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y,
   output logic         ovf,
   output logic         dz
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   logic [W-1:0] q;

   assign dz = (b == '0);

   generate
      if (SGN) begin : g_sdiv
         logic         na, nb;
         logic [W-1:0] ma, mb, mq;
         assign na  = a[W-1];
         assign nb  = b[W-1];
         assign ma  = na ? (~a + 1'b1) : a;
         assign mb  = dz ? {{(W-1){1'b0}}, 1'b1} : (nb ? (~b + 1'b1) : b);
         assign mq  = ma / mb;
         // Magnitude division then sign fix truncates toward zero.
         assign q   = (na ^ nb) ? (~mq + 1'b1) : mq;
         assign ovf = (a == MOST_NEG) && (b == '1);
      end else begin : g_udiv
         logic [W-1:0] db;
         assign db  = dz ? {{(W-1){1'b0}}, 1'b1} : b;
         assign q   = a / db;
         assign ovf = 1'b0;
      end
   endgenerate

   assign y = dz ? '0 : q;
endmodule

// File: rtl/arith4_unit.sv
module arith4_unit #(
   parameter int W       = 8,
   parameter bit SIGNED  = 1'b0,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic [1:0]   op_sel,
   output logic [W-1:0] res,
   output logic         flag_ovf,
   output logic         flag_dz,
   output logic         flag_zero,
   output logic         flag_neg,
   output logic         res_valid
);
   import calc_pkg::*;

   generate
      if (W < 2 || W > 32) begin : g_bad_width
         $error("arith4_unit: W must lie in 2..32");
      end
   endgenerate

   calc_op_e     op;
   logic [W-1:0] as_y, mul_y, div_y, nxt_res;
   logic         as_ovf, mul_ovf, div_ovf, div_dz;
   calc_flags_t  nxt_fl;

   assign op = calc_op_e'(op_sel);

   calc_addsub #(.W(W), .SGN(SIGNED)) u_as (
      .a(op_a), .b(op_b), .sub(op == OP_SUB), .y(as_y), .ovf(as_ovf));
   calc_mul #(.W(W), .SGN(SIGNED)) u_mul (
      .a(op_a), .b(op_b), .y(mul_y), .ovf(mul_ovf));
   calc_div #(.W(W), .SGN(SIGNED)) u_div (
      .a(op_a), .b(op_b), .y(div_y), .ovf(div_ovf), .dz(div_dz));

   always_comb begin
      nxt_fl = '0;
      unique case (op)
         OP_ADD, OP_SUB: begin nxt_res = as_y;  nxt_fl.ovf = as_ovf; end
         OP_MUL:         begin nxt_res = mul_y; nxt_fl.ovf = mul_ovf; end
         default:        begin
            nxt_res   = div_y;
            nxt_fl.ovf = div_ovf;
            nxt_fl.dz  = div_dz;
         end
      endcase
      nxt_fl.zero = (nxt_res == '0);
      nxt_fl.neg  = SIGNED ? nxt_res[W-1] : 1'b0;
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               res       <= '0;
               flag_ovf  <= 1'b0;
               flag_dz   <= 1'b0;
               flag_zero <= 1'b0;
               flag_neg  <= 1'b0;
               res_valid <= 1'b0;
            end else begin
               res_valid <= in_valid;
               if (in_valid) begin
                  res       <= nxt_res;
                  flag_ovf  <= nxt_fl.ovf;
                  flag_dz   <= nxt_fl.dz;
                  flag_zero <= nxt_fl.zero;
                  flag_neg  <= nxt_fl.neg;
               end
            end
         end

         // R9
         valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> res_valid);
         // R9
         idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> (!res_valid && $stable(res) && $stable(flag_ovf)));
         // R6
         dz_zero_res_chk: assert property (@(posedge clk) disable iff (rst)
            (res_valid && flag_dz) |-> (res == '0 && !flag_ovf));
         // R8
         zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
            res_valid |-> (flag_zero == (res == '0)));
         // R8
         neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
            res_valid |-> (flag_neg == (SIGNED && res[W-1])));
         // R10
         reset_clear_chk: assert property (@(posedge clk)
            rst |=> (!res_valid && res == '0 && !flag_ovf && !flag_dz));
      end else begin : g_comb
         assign res       = nxt_res;
         assign flag_ovf  = nxt_fl.ovf;
         assign flag_dz   = nxt_fl.dz;
         assign flag_zero = nxt_fl.zero;
         assign flag_neg  = nxt_fl.neg;
         assign res_valid = in_valid;
      end
   endgenerate
endmodule

// File: tb/sim_arith4_unit.sv
module sim_arith4_unit;
   localparam int  TW      = 4;
   localparam time CLK_PER = 10ns;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [TW-1:0] a = '0, b = '0;
   logic [1:0] sel = '0;

   logic [TW-1:0] r0, r1;
   logic o0, z0, n0, d0, v0, o1, z1, n1, d1, v1;

   typedef struct packed {
      logic [TW-1:0] r;
      logic ovf, dz, zero, neg;
   } exp_t;

   exp_t q0[$], q1[$];
   string t0[$], t1[$];
   int checks = 0, errors = 0;

   always #(CLK_PER / 2) clk = ~clk;

   arith4_unit #(.W(TW), .SIGNED(1'b0), .REG_OUT(1'b1)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(a), .op_b(b), .op_sel(sel),
      .res(r0), .flag_ovf(o0), .flag_dz(d0), .flag_zero(z0), .flag_neg(n0),
      .res_valid(v0));
   arith4_unit #(.W(TW), .SIGNED(1'b1), .REG_OUT(1'b1)) u1 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(a), .op_b(b), .op_sel(sel),
      .res(r1), .flag_ovf(o1), .flag_dz(d1), .flag_zero(z1), .flag_neg(n1),
      .res_valid(v1));

   // Reference model from the requirements, using plain integers.
   function automatic exp_t model(input bit sgn, input logic [TW-1:0] x,
                                  input logic [TW-1:0] y, input logic [1:0] s,
                                  output string tag);
      exp_t e;
      int ix, iy, tr, lo, hi;
      e  = '0;
      ix = sgn ? $signed(x) : int'(x);
      iy = sgn ? $signed(y) : int'(y);
      lo = sgn ? -(1 << (TW - 1)) : 0;
      hi = sgn ? (1 << (TW - 1)) - 1 : (1 << TW) - 1;
      tag = "R1";
      case (s)
         2'b00: begin tr = ix + iy; tag = sgn ? "R3" : "R2"; end
         2'b01: begin tr = ix - iy; tag = sgn ? "R3" : "R2"; end
         2'b10: begin tr = ix * iy; tag = "R4"; end
         default: begin
            if (iy == 0) begin tr = 0; e.dz = 1'b1; tag = "R6"; end
            else begin
               tr  = ix / iy;
               tag = (tr > hi) ? "R7" : "R5";
            end
         end
      endcase
      e.ovf  = (tr < lo) || (tr > hi);
      e.r    = tr[TW-1:0];
      e.zero = (e.r == '0);
      e.neg  = sgn && e.r[TW-1];
      return e;
   endfunction

   task automatic drive(input logic [TW-1:0] x, input logic [TW-1:0] y,
                        input logic [1:0] s);
      string tg;
      exp_t e;
      @(negedge clk);
      a = x; b = y; sel = s; in_valid = 1'b1;
      e = model(1'b0, x, y, s, tg); q0.push_back(e); t0.push_back(tg);
      e = model(1'b1, x, y, s, tg); q1.push_back(e); t1.push_back(tg);
   endtask

   task automatic compare(input string unit, input string tg, input exp_t got,
                          input exp_t exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s (%s/R8) %s: got r=%h ovf=%b dz=%b z=%b n=%b expected r=%h ovf=%b dz=%b z=%b n=%b",
                  tg, (tg == "R1") ? "R1" : tg, unit, got.r, got.ovf, got.dz, got.zero,
                  got.neg, exp.r, exp.ovf, exp.dz, exp.zero, exp.neg);
      end
   endtask

   // Monitor: a result is due on the falling edge after its sampling edge (R9).
   always @(negedge clk) begin
      if (!rst) begin
         if (v0) begin
            if (q0.size() == 0) begin
               checks++; errors++;
               $display("FAIL R9 unsigned: got valid=1 expected valid=0");
            end else compare("unsigned", t0.pop_front(), {r0, o0, d0, z0, n0}, q0.pop_front());
         end
         if (v1) begin
            if (q1.size() == 0) begin
               checks++; errors++;
               $display("FAIL R9 signed: got valid=1 expected valid=0");
            end else compare("signed", t1.pop_front(), {r1, o1, d1, z1, n1}, q1.pop_front());
         end
      end
   end

   task automatic check_bit(input string tg, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tg, got, exp);
      end
   endtask

   task automatic check_cleared(input string tg);
      check_bit(tg, |{r0, o0, d0, z0, n0, v0, r1, o1, d1, z1, n1, v1}, 1'b0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      logic [TW-1:0] hold0, hold1;
      repeat (3) @(negedge clk);
      check_cleared("R10 reset state");
      rst = 1'b0;
      // Exhaustive sweep R1..R8 in both modes.
      for (int s = 0; s < 4; s++)
         for (int x = 0; x < (1 << TW); x++)
            for (int y = 0; y < (1 << TW); y++)
               drive(TW'(x), TW'(y), 2'(s));
      @(negedge clk); in_valid = 1'b0;
      @(negedge clk);
      check_bit("R9 queue drained", (q0.size() + q1.size()) != 0, 1'b0);
      // R9: idle cycles leave the outputs held and valid low.
      hold0 = r0; hold1 = r1;
      repeat (4) begin
         @(negedge clk);
         check_bit("R9 idle valid", v0 | v1, 1'b0);
         check_bit("R9 idle hold", (r0 !== hold0) || (r1 !== hold1), 1'b0);
      end
      // R10: reset with a request pending clears everything.
      drive(4'h7, 4'h9, 2'b00);
      rst = 1'b1;
      q0.delete(); q1.delete(); t0.delete(); t1.delete();
      @(negedge clk);
      in_valid = 1'b0;
      check_cleared("R10 mid-run reset");
      rst = 1'b0;
      drive(4'h8, 4'hF, 2'b11);  // R7 after reset
      @(negedge clk); in_valid = 1'b0;
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      #(CLK_PER * 20000);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end
endmodule